// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a bank of interrupt request lines and presents the processor core with one 3-bit request level, where 7 is the most urgent and 0 means nothing is requested. Most sources are fully programmable: a per-source control word sets a level, a 2-bit sub-priority used inside that level, and a mask bit. A small group of sources at the top of the index range have hard-wired levels, and only their mask bit can be changed. A global mask-all bit silences the whole controller.

The block resolves the winning source among all eligible requests. The core can fetch that source's vector in two ways: with a hardware acknowledge strobe, or by reading the acknowledge address on the configuration bus. Each vector is a fixed base plus the source index. When no source is eligible, the block returns a defined spurious vector. A registered wake-up output tells a core in low-power stop that an interrupt above its current mask level is waiting.

Top module: `prio_vec_intc`

## Requirements
- R1: After synchronous reset, `irq_level_o`, `wakeup_o`, `hw_ack_vld_o` and `bus_rdata_o` are 0. Every source is masked and mask-all is clear, so a programmable source reads back 0x20.
- R2: The control word at address i (i < NUM_SRC) holds sub-priority in bits [1:0], level in bits [4:2] and mask in bit [5]. Bits [7:6] read as 0. Address NUM_SRC is the global address: a write of bit 0 sets mask-all. Reads are registered and return data one cycle after `bus_re_i`.
- R3: The last NUM_FIXED sources (fixed index k = i - (NUM_SRC - NUM_FIXED)) have level 7-k and sub-priority 0. Writes to their level and sub-priority are ignored, and only the mask bit is writable.
- R4: A source is eligible only when its request line is high, its mask bit is 0 and its level is nonzero. A masked source, or one at level 0, has no effect on any output.
- R5: `irq_level_o` shows the highest eligible level one cycle after the inputs and configuration that produced it. It is 0 when no source is eligible.
- R6: Among eligible sources at the top level, the higher sub-priority wins. If sub-priorities are also equal, the lower source index wins.
- R7: One cycle after `hw_ack_i`, `hw_ack_vld_o` is high for that cycle and `hw_ack_vec_o` holds VEC_BASE + index of the winner (default base 64).
- R8: A read of the global address returns the same vector that a hardware acknowledge in the same cycle would return.
- R9: With no eligible source, or with mask-all set, both acknowledge paths return SPUR_VEC (default 24).
- R10: While mask-all is set, `irq_level_o` and `wakeup_o` are 0.
- R11: `wakeup_o` is 1 when the presented level is greater than `core_mask_i` or equal to 7. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_SRC | Request lines, one per source |
| bus_we_i | input | 1 | Configuration write strobe |
| bus_re_i | input | 1 | Configuration read strobe |
| bus_addr_i | input | ADDR_W | Word address (NUM_SRC = global/acknowledge) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| core_mask_i | input | 3 | Current core interrupt mask level |
| hw_ack_i | input | 1 | Hardware acknowledge strobe |
| hw_ack_vld_o | output | 1 | Vector valid, one cycle after the strobe |
| hw_ack_vec_o | output | 8 | Acknowledged vector |
| irq_level_o | output | 3 | Encoded request level to the core |
| wakeup_o | output | 1 | Wake-up request for low-power stop |

## Verification
On every cycle, assertions check four things: the mask-all write and its silencing of the level and wake-up outputs, that any chosen winner is actually eligible, that acknowledge pulses and their vectors fall in the legal range, and that wake-up never appears without a level. Whether the winner is really the best candidate cannot be seen from a single cycle. That includes sub-priority and index tie-breaks, fixed-level protection, readback formats and the exact vector arithmetic. These only show up in the bench's sweeps, which compare them against a model computed from the requirements.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W = 3;
  localparam int SUB_W = 2;
  localparam int CFG_W = 1 + LVL_W + SUB_W;

  typedef struct packed {
    logic             mask;
    logic [LVL_W-1:0] lvl;
    logic [SUB_W-1:0] sub;
  } src_cfg_t;

  localparam src_cfg_t CFG_RST = '{mask: 1'b1, lvl: '0, sub: '0};
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int ADDR_W    = $clog2(NUM_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output src_cfg_t          cfg_o [NUM_SRC],
  output logic              mask_all_o
);
  localparam int NUM_PROG = NUM_SRC - NUM_FIXED;

  src_cfg_t             prog_q [NUM_PROG];
  logic [NUM_FIXED-1:0] fixed_mask_q;
  logic                 mask_all_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PROG; i++) prog_q[i] <= CFG_RST;
      fixed_mask_q <= '1;
      mask_all_q   <= 1'b0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_PROG; i++)
        if (addr_i == ADDR_W'(i)) prog_q[i] <= src_cfg_t'(wdata_i[CFG_W-1:0]);
      for (int k = 0; k < NUM_FIXED; k++)
        if (addr_i == ADDR_W'(NUM_PROG + k)) fixed_mask_q[k] <= wdata_i[CFG_W-1];
      if (addr_i == ADDR_W'(NUM_SRC)) mask_all_q <= wdata_i[0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cfg
    if (g < NUM_PROG) begin : g_prog
      assign cfg_o[g] = prog_q[g];
    end else begin : g_fixed
      assign cfg_o[g] = '{mask: fixed_mask_q[g-NUM_PROG],
                          lvl:  LVL_W'(7 - (g - NUM_PROG)),
                          sub:  '0};
    end
  end

  assign mask_all_o = mask_all_q;

  AST_MASKALL_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(we_i && addr_i == ADDR_W'(NUM_SRC)) |-> mask_all_o == $past(wdata_i[0])); // R10
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] irq_i,
  input  src_cfg_t           cfg_i [NUM_SRC],
  output logic               win_vld_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [LVL_W-1:0]   win_lvl_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = irq_i[g] && !cfg_i[g].mask && (cfg_i[g].lvl != '0);
  end

  logic [LVL_W+SUB_W-1:0] best_key;

  // Ascending scan with strict compare: an equal key never displaces a lower index.
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    best_key  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_vld_o || {cfg_i[i].lvl, cfg_i[i].sub} > best_key)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        best_key  = {cfg_i[i].lvl, cfg_i[i].sub};
      end
    end
    win_lvl_o = best_key[LVL_W+SUB_W-1:SUB_W];
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int VEC_BASE  = 64,
  parameter int SPUR_VEC  = 24,
  parameter int ADDR_W    = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               bus_we_i,
  input  logic               bus_re_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  input  logic [2:0]         core_mask_i,
  input  logic               hw_ack_i,
  output logic               hw_ack_vld_o,
  output logic [7:0]         hw_ack_vec_o,
  output logic [2:0]         irq_level_o,
  output logic               wakeup_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  src_cfg_t         cfg [NUM_SRC];
  logic             mask_all;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;

  intc_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .cfg_o(cfg), .mask_all_o(mask_all));

  intc_resolver #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_res (
    .irq_i(irq_i), .cfg_i(cfg), .win_vld_o(win_vld), .win_idx_o(win_idx), .win_lvl_o(win_lvl));

  logic       live;
  logic [2:0] eff_lvl;
  logic [7:0] cur_vec;
  logic [7:0] rd_word;

  assign live    = win_vld && !mask_all;
  assign eff_lvl = live ? win_lvl : 3'd0;
  assign cur_vec = live ? 8'(VEC_BASE) + 8'(win_idx) : 8'(SPUR_VEC);

  always_comb begin
    rd_word = '0;
    if (bus_addr_i == ADDR_W'(NUM_SRC)) rd_word = cur_vec;
    else
      for (int i = 0; i < NUM_SRC; i++)
        if (bus_addr_i == ADDR_W'(i)) rd_word = 8'(cfg[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level_o  <= '0;
      wakeup_o     <= 1'b0;
      hw_ack_vld_o <= 1'b0;
      hw_ack_vec_o <= '0;
      bus_rdata_o  <= '0;
    end else begin
      irq_level_o  <= eff_lvl;
      wakeup_o     <= live && (eff_lvl > core_mask_i || eff_lvl == 3'd7);
      hw_ack_vld_o <= hw_ack_i;
      if (hw_ack_i) hw_ack_vec_o <= cur_vec;
      if (bus_re_i) bus_rdata_o <= rd_word;
    end
  end

  AST_MASKALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(mask_all) |-> (irq_level_o == 3'd0 && !wakeup_o)); // R10
  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> (irq_i[win_idx] && !cfg[win_idx].mask && cfg[win_idx].lvl != '0)); // R4
  AST_NO_REQ_NO_LVL: assert property (@(posedge clk) disable iff (rst)
    !$past(|irq_i) |-> irq_level_o == 3'd0); // R5
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    hw_ack_vld_o |-> $past(hw_ack_i)); // R7
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    hw_ack_vld_o |-> (int'(hw_ack_vec_o) == SPUR_VEC ||
      (int'(hw_ack_vec_o) >= VEC_BASE && int'(hw_ack_vec_o) < VEC_BASE + NUM_SRC))); // R9
  AST_WAKE_NEEDS_LVL: assert property (@(posedge clk) disable iff (rst)
    wakeup_o |-> irq_level_o != 3'd0); // R11
endmodule

// File: tb/prio_vec_intc_tb.sv
`timescale 1ns/1ps
module prio_vec_intc_tb;
  localparam int NS = 15, NF = 3, NP = NS - NF, AW = 4, BASE = 64, SPUR = 24;

  logic          clk = 0, rst = 1;
  logic [NS-1:0] irq_i = '0;
  logic          bus_we_i = 0, bus_re_i = 0, hw_ack_i = 0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [7:0]    bus_wdata_i = '0;
  logic [7:0]    bus_rdata_o, hw_ack_vec_o;
  logic [2:0]    core_mask_i = '0, irq_level_o;
  logic          hw_ack_vld_o, wakeup_o;

  prio_vec_intc #(.NUM_SRC(NS), .NUM_FIXED(NF), .VEC_BASE(BASE), .SPUR_VEC(SPUR), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .irq_i(irq_i), .bus_we_i(bus_we_i), .bus_re_i(bus_re_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .core_mask_i(core_mask_i), .hw_ack_i(hw_ack_i), .hw_ack_vld_o(hw_ack_vld_o),
    .hw_ack_vec_o(hw_ack_vec_o), .irq_level_o(irq_level_o), .wakeup_o(wakeup_o));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_lvl [NS], m_sub [NS], m_msk [NS];
  int m_all = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic wr(int a, int d);
    bus_we_i = 1; bus_addr_i = AW'(a); bus_wdata_i = 8'(d);
    @(negedge clk);
    bus_we_i = 0;
    if (a < NP) begin m_msk[a] = (d >> 5) & 1; m_lvl[a] = (d >> 2) & 7; m_sub[a] = d & 3; end
    else if (a < NS) m_msk[a] = (d >> 5) & 1;
    else if (a == NS) m_all = d & 1;
  endtask

  task automatic rd(int a, output int d);
    bus_re_i = 1; bus_addr_i = AW'(a);
    @(negedge clk);
    bus_re_i = 0;
    d = int'(bus_rdata_o);
  endtask

  // Expected level/vector from R4, R5, R6, R7, R9, R10.
  task automatic model(logic [NS-1:0] irq, output int lvl, output int vec);
    int best = -1, bk = -1;
    for (int i = 0; i < NS; i++)
      if (irq[i] && m_msk[i] == 0 && m_lvl[i] != 0 && m_lvl[i] * 4 + m_sub[i] > bk) begin
        bk = m_lvl[i] * 4 + m_sub[i]; best = i;
      end
    if (m_all != 0 || best < 0) begin lvl = 0; vec = SPUR; end
    else begin lvl = m_lvl[best]; vec = BASE + best; end
  endtask

  task automatic apply(logic [NS-1:0] irq, int cm, string tag);
    int el, ev, d;
    model(irq, el, ev);
    irq_i = irq; core_mask_i = 3'(cm);
    @(negedge clk);
    chk({tag, " R5 level"}, int'(irq_level_o), el);
    chk({tag, " R11 wakeup"}, int'(wakeup_o), (el != 0 && (el > cm || el == 7)) ? 1 : 0);
    hw_ack_i = 1;
    rd(NS, d);
    hw_ack_i = 0;
    chk({tag, " R7 hw vector"}, int'(hw_ack_vec_o), ev);
    chk({tag, " R7 hw valid"}, int'(hw_ack_vld_o), 1);
    chk({tag, " R8 sw vector"}, d, ev);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d;
    for (int i = 0; i < NS; i++) begin
      m_msk[i] = 1; m_sub[i] = 0; m_lvl[i] = (i < NP) ? 0 : 7 - (i - NP);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset level", int'(irq_level_o), 0);
    chk("R1 reset wakeup", int'(wakeup_o), 0);
    chk("R1 reset ack valid", int'(hw_ack_vld_o), 0);
    chk("R1 reset rdata", int'(bus_rdata_o), 0);
    rd(4, d);  chk("R1 reset cfg readback", d, 8'h20);
    rd(NP, d); chk("R3 fixed reset readback", d, 8'h20 | (7 << 2));
    apply('1, 0, "R1 all masked");

    // R2 readback format, R3 fixed protection
    wr(5, 8'hFF);  rd(5, d);  chk("R2 upper bits read 0", d, 8'h3F);
    wr(5, 8'h0D);  rd(5, d);  chk("R2 field readback", d, 8'h0D);
    wr(NP + 1, 8'h1F); rd(NP + 1, d); chk("R3 fixed level kept", d, 8'h18);
    wr(5, 8'h20); wr(NP + 1, 8'h20);

    // Sweep each source alone over all levels (R3, R5, R7, R11)
    for (int i = 0; i < NP; i++)
      for (int l = 1; l < 8; l++) begin
        wr(i, (l << 2) | (l & 3));
        apply(NS'(1) << i, l % 8 == 7 ? 6 : (i % 7), "sweep prog");
        wr(i, 8'h20);
      end
    for (int k = 0; k < NF; k++) begin
      wr(NP + k, 8'h03);
      apply(NS'(1) << (NP + k), 6 - k, "R3 sweep fixed");
      wr(NP + k, 8'h20);
    end

    // R6 ties
    wr(3, (5 << 2) | 2); wr(7, (5 << 2) | 2);
    apply(NS'((1 << 3) | (1 << 7)), 0, "R6 index tie");
    wr(2, (5 << 2) | 1); wr(9, (5 << 2) | 3);
    apply(NS'((1 << 2) | (1 << 9)), 0, "R6 sub-priority");
    // R4 masked or level-0 source ignored
    wr(9, 8'h20 | (7 << 2) | 3); wr(10, 8'h00);
    apply(NS'((1 << 2) | (1 << 9) | (1 << 10)), 0, "R4 masked ignored");
    // R9 nothing pending, R10 mask-all
    apply('0, 0, "R9 spurious");
    wr(NS, 1);
    apply(NS'((1 << 2) | (1 << 3)), 0, "R10 mask-all");
    wr(NS, 0);

    // Random configurations
    for (int t = 0; t < 300; t++) begin
      for (int i = 0; i < NP; i++) wr(i, int'(rnd() & 32'h3F) & ((rnd() & 3) == 0 ? 8'h3F : 8'h1F));
      for (int k = 0; k < NF; k++) wr(NP + k, (rnd() & 1) ? 8'h20 : 8'h00);
      wr(NS, (rnd() & 7) == 0 ? 1 : 0);
      apply(NS'(rnd()), int'(rnd() & 7), "R6 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule